// File: doc/BRIEF.md
# Square-and-Multiply Modular Exponentiation Engine

This block raises a single-word base to a single-word power and reduces the result modulo a single-word modulus, c = m^e mod n, with 32-bit operands by default. A host places m, e and n on parallel inputs and pulses `start` while `ready` is high. `ready` then falls and stays low until the result appears on `c`. After that, `c` holds the result until the next accepted start.

Internally the base is first reduced modulo n. The accumulator starts at 1 mod n. A bit index then walks the exponent from its highest set bit down to bit 0. Every step squares the accumulator. A step multiplies the accumulator by the reduced base only when the exponent bit it is visiting is 1. Every modular product comes from a bit-serial unit that consumes one multiplier bit per cycle: it doubles, conditionally adds, and subtracts the modulus when the value reaches it, on a one-bit-wider intermediate. No wide multiplier is used. The modulus must be nonzero.

Top module: `modexp_engine`

## Requirements
- R1: After a completed operation `c` equals m^e mod n for any n >= 1, and `c` is below n.
- R2: The operations 3^7 mod 11, 251^251 mod 257 and 0x81^0x41 mod 0x87 give 9, 183 and 0x36.
- R3: After reset `ready` is 1 and `c` is 0.
- R4: A start sampled while `ready` is 1 makes `ready` 0 from the next cycle on. `ready` returns to 1 together with a valid `c`, and `c` does not change while `ready` stays 1.
- R5: A start pulse, and any change of m, e or n, while `ready` is 0 is ignored: the running result and its timing are unchanged.
- R6: An exponent of 0 gives 1 when n > 1, and a modulus of 1 gives 0 for any m and e.
- R7: A base greater than or equal to the modulus is reduced first, so the result equals the result for (m mod n).
- R8: Moduli up to 2^32-1 and an exponent of all ones give correct results; the intermediate sum never overflows.
- R9: `ready` stays low for exactly K*(W+2) cycles, where W is the operand width and K = 1 when e = 0. Otherwise K = 1 + (index of the highest set bit of e + 1) + (number of ones in e). An exponent of 65537 therefore costs 1 + 17 + 2 = 20 products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, accepted only while ready is 1 |
| m | input | W | Base |
| e | input | W | Exponent |
| n | input | W | Modulus, nonzero |
| ready | output | 1 | Idle and result valid |
| c | output | W | Result m^e mod n |

## Verification
The hardest condition to reach from the ports is a second request that arrives mid-operation with different operands. The bench launches one exponentiation, waits several product steps, then drives a start pulse with new m, e and n. The scoreboard entry of the first operation, including its exact busy length, must still match. The widest intermediate sum only occurs with a modulus just below 2^32 and operands near it, so one case uses such a modulus together with an all-ones exponent. The busy length for every case is predicted from the exponent's bit count and top bit, which exposes any skipped or extra product.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REDUCE = 2'd1,
    ST_SQUARE = 2'd2,
    ST_MULT   = 2'd3
  } me_state_e;
endpackage

// File: rtl/me_rst_sync.sv
module me_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/me_msb_index.sv
module me_msb_index #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/me_modmul.sv
// Bit-serial modular product: res = a*b mod n, multiplier bits MSB first.
// Requires a < n. Busy for W cycles after go, done pulses once.
module me_modmul #(
  parameter int W = 32,
  localparam int IW = $clog2(W),
  localparam int XW = W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res
);
  logic [W-1:0]  acc_q, acc_n, a_q, b_q, b_n;
  logic [IW-1:0] cnt_q, cnt_n;
  logic          busy_n, done_n, a_en;
  logic [XW-1:0] dbl, sum, n_x;

  // one reduction step on a 33-bit value
  always_comb begin
    n_x = {1'b0, n};
    dbl = {acc_q, 1'b0};
    if (dbl >= n_x) dbl = dbl - n_x;
    sum = dbl + (b_q[W-1] ? {1'b0, a_q} : '0);
    if (sum >= n_x) sum = sum - n_x;
  end

  always_comb begin
    acc_n  = acc_q;
    b_n    = b_q;
    cnt_n  = cnt_q;
    busy_n = busy;
    done_n = 1'b0;
    a_en   = 1'b0;
    if (go) begin
      acc_n  = '0;
      b_n    = b;
      cnt_n  = '0;
      busy_n = 1'b1;
      a_en   = 1'b1;
    end else if (busy) begin
      acc_n = sum[W-1:0];
      b_n   = {b_q[W-2:0], 1'b0};
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == IW'(W - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      b_q   <= '0;
      a_q   <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      acc_q <= acc_n;
      b_q   <= b_n;
      cnt_q <= cnt_n;
      busy  <= busy_n;
      done  <= done_n;
      if (a_en) a_q <= a;
    end
  end

  assign res = acc_q;
endmodule

// File: rtl/modexp_engine.sv
module modexp_engine
  import modexp_pkg::*;
#(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] m,
  input  logic [W-1:0] e,
  input  logic [W-1:0] n,
  output logic         ready,
  output logic [W-1:0] c
);
  logic          rst_sync_n;
  me_state_e     st_q, st_n;
  logic [W-1:0]  m_q, e_q, n_q, p_q, z_q, z_n;
  logic [IW-1:0] idx_q, idx_n, top_idx;
  logic          cap_en, p_en, z_en, idx_en;
  logic          mul_go, go_n, mul_busy, mul_done;
  logic [W-1:0]  op_a, op_b, mul_res;

  me_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  me_msb_index #(.W(W)) u_msb (.val(e_q), .idx(top_idx));

  me_modmul #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_sync_n), .go(mul_go), .a(op_a), .b(op_b), .n(n_q),
    .busy(mul_busy), .done(mul_done), .res(mul_res)
  );

  // operand selection per phase
  always_comb begin
    op_a = z_q;
    op_b = z_q;
    case (st_q)
      ST_REDUCE: begin op_a = W'(1); op_b = m_q; end
      ST_MULT:   op_b = p_q;
      default:   ;
    endcase
  end

  always_comb begin
    st_n   = st_q;
    go_n   = 1'b0;
    cap_en = 1'b0;
    p_en   = 1'b0;
    z_en   = 1'b0;
    z_n    = z_q;
    idx_en = 1'b0;
    idx_n  = idx_q;
    case (st_q)
      ST_IDLE: if (start) begin
        cap_en = 1'b1;
        st_n   = ST_REDUCE;
        go_n   = 1'b1;
      end
      ST_REDUCE: if (mul_done) begin
        p_en = 1'b1;
        z_en = 1'b1;
        z_n  = (n_q == W'(1)) ? '0 : W'(1);
        if (e_q == '0) begin
          st_n = ST_IDLE;
        end else begin
          idx_en = 1'b1;
          idx_n  = top_idx;
          st_n   = ST_SQUARE;
          go_n   = 1'b1;
        end
      end
      ST_SQUARE: if (mul_done) begin
        z_en = 1'b1;
        z_n  = mul_res;
        if (e_q[idx_q]) begin
          st_n = ST_MULT;
          go_n = 1'b1;
        end else if (idx_q == '0) begin
          st_n = ST_IDLE;
        end else begin
          idx_en = 1'b1;
          idx_n  = idx_q - 1'b1;
          go_n   = 1'b1;
        end
      end
      ST_MULT: if (mul_done) begin
        z_en = 1'b1;
        z_n  = mul_res;
        if (idx_q == '0) begin
          st_n = ST_IDLE;
        end else begin
          idx_en = 1'b1;
          idx_n  = idx_q - 1'b1;
          st_n   = ST_SQUARE;
          go_n   = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      mul_go <= 1'b0;
      m_q    <= '0;
      e_q    <= '0;
      n_q    <= '0;
      p_q    <= '0;
      z_q    <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_n;
      mul_go <= go_n;
      if (cap_en) begin
        m_q <= m;
        e_q <= e;
        n_q <= n;
      end
      if (p_en)   p_q   <= mul_res;
      if (z_en)   z_q   <= z_n;
      if (idx_en) idx_q <= idx_n;
    end
  end

  assign ready = (st_q == ST_IDLE);
  assign c     = z_q;
endmodule

// File: rtl/modexp_engine_chk.sv
module modexp_engine_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic [W-1:0] c,
  input logic [W-1:0] n_q,
  input logic         mul_go,
  input logic         mul_busy
);
  p_below_mod_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && n_q != '0) |-> (c < n_q));

  p_drop_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start) |=> !ready);

  p_hold_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(c));

  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !$past(ready)) |-> $stable(n_q));

  p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |-> !mul_busy);
endmodule

bind modexp_engine modexp_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .ready(ready), .c(c),
  .n_q(n_q), .mul_go(mul_go), .mul_busy(mul_busy)
);

// File: tb/tb_modexp_engine.sv
`timescale 1ns/1ps
module tb_modexp_engine;
  localparam int W = 32;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] m = '0, e = '0, n = '0;
  logic         ready;
  logic [W-1:0] c;

  int checks = 0;
  int fails  = 0;
  bit done_all = 0;

  typedef struct {
    logic [W-1:0] val;
    int           lat;
    string        tag;
  } exp_t;
  exp_t sb[$];

  modexp_engine dut (.clk(clk), .rst_n(rst_n), .start(start), .m(m), .e(e),
                     .n(n), .ready(ready), .c(c));

  always #10 clk = ~clk;

  // independent reference: right-to-left binary method on 64-bit values
  function automatic logic [W-1:0] ref_pow(logic [W-1:0] b, logic [W-1:0] x, logic [W-1:0] md);
    logic [63:0] r, s, mm;
    logic [W-1:0] k;
    mm = {32'd0, md};
    r  = 64'd1 % mm;
    s  = {32'd0, b} % mm;
    k  = x;
    while (k != 0) begin
      if (k[0]) r = (r * s) % mm;
      s = (s * s) % mm;
      k = k >> 1;
    end
    return r[W-1:0];
  endfunction

  function automatic int ref_lat(logic [W-1:0] x);
    int hi = -1, ones = 0;
    for (int i = 0; i < W; i++) if (x[i]) begin hi = i; ones++; end
    if (x == 0) return W + 2;
    return (1 + hi + 1 + ones) * (W + 2);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic launch(logic [W-1:0] bm, logic [W-1:0] be, logic [W-1:0] bn, string tag);
    exp_t it;
    while (!ready) @(negedge clk);
    it.val = ref_pow(bm, be, bn);
    it.lat = ref_lat(be);
    it.tag = tag;
    sb.push_back(it);
    m = bm; e = be; n = bn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 ready low after start", {63'd0, ready}, 64'd0);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: measure busy length, compare result on ready rise
  int  busy_cnt = 0;
  bit  prev_rdy = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ready) busy_cnt++;
      else if (!prev_rdy) begin
        exp_t it;
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4 unexpected completion actual=0x%0h expected=none", c);
        end else begin
          it = sb.pop_front();
          check({it.tag, " result"}, {32'd0, c}, {32'd0, it.val});
          check("R9 busy length", 64'(busy_cnt), 64'(it.lat));
        end
        busy_cnt = 0;
      end
      prev_rdy = ready;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 ready after reset", {63'd0, ready}, 64'd1);
    check("R3 c after reset", {32'd0, c}, 64'd0);

    launch(32'd3, 32'd7, 32'd11, "R2 3^7 mod 11");
    drain(); check("R2 value 9", {32'd0, c}, 64'd9);
    launch(32'd251, 32'd251, 32'd257, "R2 251^251 mod 257");
    drain(); check("R2 value 183", {32'd0, c}, 64'd183);
    launch(32'h81, 32'h41, 32'h87, "R2 0x81^0x41 mod 0x87");
    drain(); check("R2 value 0x36", {32'd0, c}, 64'h36);

    // R4: result held while idle
    repeat (20) @(negedge clk);
    check("R4 c held while idle", {32'd0, c}, 64'h36);

    launch(32'h12345678, 32'h00010001, 32'hF077656F, "R1 e=65537");
    drain();
    launch(32'd5, 32'd0, 32'd13, "R6 e=0");
    drain(); check("R6 e=0 gives 1", {32'd0, c}, 64'd1);
    launch(32'hDEADBEEF, 32'h1234, 32'd1, "R6 n=1");
    drain(); check("R6 n=1 gives 0", {32'd0, c}, 64'd0);
    launch(32'd1000, 32'd3, 32'd7, "R7 m>=n");
    drain(); check("R7 same as reduced base", {32'd0, c}, {32'd0, ref_pow(32'd6, 32'd3, 32'd7)});
    launch(32'hFFFFFFFA, 32'hFFFFFFFF, 32'hFFFFFFFB, "R8 wide modulus");
    drain();
    launch(32'h89ABCDEF, 32'h80000001, 32'hFFFFFFFF, "R8 top bit exponent");
    drain();

    // R5: a second request mid-operation must be ignored
    launch(32'd77, 32'd12345, 32'd100003, "R5 busy start");
    repeat (90) @(negedge clk);
    m = 32'd2; e = 32'd3; n = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5 still busy", {63'd0, ready}, 64'd0);
    drain();
    repeat (40) @(negedge clk);
    check("R5 no extra run", {63'd0, ready}, 64'd1);

    for (int k = 0; k < 4; k++) begin
      launch(32'h1000_0000 + 32'(k * 977), 32'(k * 3 + 2), 32'h7FFF_0000 + 32'(k * 13 + 1), "R1 sweep");
      drain();
    end

    done_all = 1;
  end

  initial begin
    int cyc = 0;
    while (!done_all && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_all) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule